// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits on the host side of a byte-wide parallel flash and turns one high-level request into the bus traffic the flash expects. A request names an operation: program one byte, erase one sector, or erase the whole array. It carries a target address, a data byte and a sector index. The sequencer emits the fixed unlock and command writes in order, then switches to reading the flash. It keeps reading until bit 7 of the returned byte shows the embedded operation has finished. One further read confirms that result, and then the sequencer raises a one-cycle completion pulse.

The request side is a valid/ready stream. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a host that holds `req_valid` during an operation is simply stalled.

The bus side is also valid/ready. `bus_valid` with its address, write flag and write data stays frozen until `bus_ready` is seen high. Read data returns later on `rd_valid`/`rd_data`, which has no back-pressure.

Each operation has its own poll limit. If that many reads fail to match, the sequencer abandons the operation, pulses `timeout_err` and becomes idle again.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `bus_valid`, `done` and `timeout_err` are 0 and `req_ready` is 1.
- R2: Op code 0 (program) writes exactly four times, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the request data to the request address.
- R3: Op code 1 (sector erase) writes six times: 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, then 0x30 to the sector base. The sector base is the sector index placed in the top SECT_W address bits, with all lower bits zero.
- R4: Op code 2 (chip erase) writes the same five leading writes as R3, then 0x10 to 0x5555.
- R5: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold their values into the next cycle.
- R6: After the last write, the sequencer issues reads with `bus_write` 0. It reads the request address for a program, the sector base for a sector erase, and address 0 for a chip erase. It keeps reading until `rd_data[7]` equals the expected bit: the data's bit 7 for a program, 1 for either erase.
- R7: After the first matching read, one confirm read is issued. If the confirm read also matches, `done` pulses for one cycle on the clock after its `rd_valid`, and `busy` drops at the same time. If the confirm read does not match, it counts as a miss and polling resumes.
- R8: Once the number of mismatching reads reaches the operation's limit (PROG_POLLS, SECT_POLLS or CHIP_POLLS), `timeout_err` pulses for one cycle. The sequencer becomes idle and `done` does not pulse.
- R9: `busy` is high from the clock after acceptance until the end of the operation, and `req_ready` is low for the whole of that time. A request held valid while busy causes no extra bus traffic and no change of target.
- R10: Op code 3 is accepted but does nothing: no bus request, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer can take a request (idle) |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 no operation |
| req_addr | input | ADDR_W | Byte address for program |
| req_data | input | 8 | Byte to program |
| req_sector | input | SECT_W | Sector index for sector erase |
| bus_valid | output | 1 | Bus access request valid |
| bus_ready | input | 1 | Bus controller takes the access |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 8 | Write data |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation confirmed complete |
| timeout_err | output | 1 | One-cycle pulse: poll limit reached |

## Verification
The assertions assume the bus controller answers each accepted read with exactly one `rd_valid`. They also assume it never returns read data while no read is outstanding. The testbench responder obeys both rules: it schedules one response, two cycles after each read handshake, and stays silent otherwise. The flash model flips bit 7 for a set number of reads, and can corrupt one chosen read to exercise the confirm path. It drops `bus_ready` on a fixed pattern so that every write and read sees back-pressure at some point.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } fseq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RD   = 2'd2,
    ST_WAIT = 2'd3
  } fseq_st_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
  localparam logic [7:0]  KEY_BYTE_B = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE  = 8'h80;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam int          PROG_STEPS = 4;
  localparam int          ERASE_STEPS = 6;
endpackage

// File: rtl/fseq_cmd_rom.sv
module fseq_cmd_rom
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  fseq_op_e          op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  input  logic [ADDR_W-1:0] sect_base,
  output logic [ADDR_W-1:0] w_addr,
  output logic [7:0]        w_data,
  output logic              last
);
  localparam logic [ADDR_W-1:0] A_KEY1 = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] A_KEY2 = ADDR_W'(KEY_ADDR_B);

  always_comb begin
    w_addr = A_KEY1;
    w_data = KEY_BYTE_A;
    last   = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin w_addr = A_KEY1; w_data = KEY_BYTE_A; end
        3'd1: begin w_addr = A_KEY2; w_data = KEY_BYTE_B; end
        3'd2: begin w_addr = A_KEY1; w_data = CMD_PROG;   end
        default: begin w_addr = tgt_addr; w_data = tgt_data; last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin w_addr = A_KEY1; w_data = KEY_BYTE_A; end
        3'd1: begin w_addr = A_KEY2; w_data = KEY_BYTE_B; end
        3'd2: begin w_addr = A_KEY1; w_data = CMD_ERASE;  end
        3'd3: begin w_addr = A_KEY1; w_data = KEY_BYTE_A; end
        3'd4: begin w_addr = A_KEY2; w_data = KEY_BYTE_B; end
        default: begin
          last = 1'b1;
          if (op == OP_SECT) begin
            w_addr = sect_base;
            w_data = CMD_SECT;
          end else begin
            w_addr = A_KEY1;
            w_data = CMD_CHIP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fseq_poll_ctr.sv
module fseq_poll_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          miss,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = miss && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear || expire) cnt_q <= '0;
    else if (miss)            cnt_q <= cnt_q + CW'(1);
  end

  // R8: the miss count never passes the limit of the operation in flight
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> cnt_q < limit);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_W     = 3,
  parameter int PROG_POLLS = 300,
  parameter int SECT_POLLS = 15000000,
  parameter int CHIP_POLLS = 64000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [SECT_W-1:0] req_sector,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  localparam int MAXP1 = (PROG_POLLS > SECT_POLLS) ? PROG_POLLS : SECT_POLLS;
  localparam int MAXP  = (MAXP1 > CHIP_POLLS) ? MAXP1 : CHIP_POLLS;
  localparam int CW    = $clog2(MAXP + 1);
  localparam int LOW_W = ADDR_W - SECT_W;

  fseq_st_e          st_q;
  fseq_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [SECT_W-1:0] sect_q;
  logic [2:0]        step_q;
  logic              confirm_q;
  logic              done_q, err_q;

  logic [ADDR_W-1:0] sect_base, poll_addr, rom_addr;
  logic [7:0]        rom_data;
  logic              rom_last, want7, match, miss, expire;
  logic [CW-1:0]     limit;

  assign sect_base = {sect_q, {LOW_W{1'b0}}};

  fseq_cmd_rom #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rom (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .sect_base(sect_base), .w_addr(rom_addr), .w_data(rom_data), .last(rom_last)
  );

  always_comb begin
    case (op_q)
      OP_PROG: begin poll_addr = addr_q;    want7 = data_q[7]; limit = CW'(PROG_POLLS); end
      OP_SECT: begin poll_addr = sect_base; want7 = 1'b1;      limit = CW'(SECT_POLLS); end
      default: begin poll_addr = '0;        want7 = 1'b1;      limit = CW'(CHIP_POLLS); end
    endcase
  end

  assign match = (rd_data[7] == want7);
  assign miss  = (st_q == ST_WAIT) && rd_valid && !match;

  fseq_poll_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(st_q == ST_IDLE),
    .miss(miss), .limit(limit), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_PROG;
      addr_q    <= '0;
      data_q    <= '0;
      sect_q    <= '0;
      step_q    <= '0;
      confirm_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid && fseq_op_e'(req_op) != OP_NONE) begin
            op_q      <= fseq_op_e'(req_op);
            addr_q    <= req_addr;
            data_q    <= req_data;
            sect_q    <= req_sector;
            step_q    <= '0;
            confirm_q <= 1'b0;
            st_q      <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (bus_ready) begin
            if (rom_last) st_q <= ST_RD;
            else          step_q <= step_q + 3'd1;
          end
        end
        ST_RD: begin
          if (bus_ready) st_q <= ST_WAIT;
        end
        default: begin
          if (rd_valid) begin
            if (match) begin
              if (confirm_q) begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                confirm_q <= 1'b1;
                st_q      <= ST_RD;
              end
            end else begin
              confirm_q <= 1'b0;
              if (expire) begin
                err_q <= 1'b1;
                st_q  <= ST_IDLE;
              end else begin
                st_q <= ST_RD;
              end
            end
          end
        end
      endcase
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign busy        = (st_q != ST_IDLE);
  assign bus_valid   = (st_q == ST_CMD) || (st_q == ST_RD);
  assign bus_write   = (st_q == ST_CMD);
  assign bus_addr    = (st_q == ST_CMD) ? rom_addr : poll_addr;
  assign bus_wdata   = (st_q == ST_CMD) ? rom_data : 8'h00;
  assign done        = done_q;
  assign timeout_err = err_q;

  // R5: a pending bus request is frozen under back-pressure
  a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
      && $stable(bus_write) && $stable(bus_wdata));
  // R7: completion is reported only on the clock after a read return
  a_r7_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_valid) && !busy && !timeout_err);
  // R8: a timeout leaves the sequencer idle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !busy && $past(rd_valid));
  // R2, R3, R4: the command step stays inside the sequence of the operation
  a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_CMD |-> (op_q == OP_PROG) ? (step_q < 3'(PROG_STEPS))
                                          : (step_q < 3'(ERASE_STEPS)));
  // R6: reads only appear after the command writes of the operation
  a_r6_read_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && !$past(busy) |-> 1'b0);
endmodule

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 19, SW = 3, PP = 6, SP = 8, CP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, bus_ready = 1'b1, rd_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0, rd_data = '0;
  logic [SW-1:0] req_sector = '0;
  logic req_ready, bus_valid, bus_write, busy, done, timeout_err;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;

  always #5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .SECT_W(SW), .PROG_POLLS(PP), .SECT_POLLS(SP),
                  .CHIP_POLLS(CP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_sector(req_sector), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .timeout_err(timeout_err));

  int checks = 0, failures = 0, cyc = 0;
  int n_wr = 0, n_rd = 0, n_done = 0, n_err = 0;
  // reference model
  int ph = 0, m_op = 0, m_lim = 0, m_miss = 0;
  bit m_exp = 0, m_conf = 0, m_done = 0, m_err = 0;
  logic [AW-1:0] m_pa = '0;
  logic [AW-1:0] qa[$];
  logic [7:0] qd[$];
  // flash responder
  int fl_busy = 0, fl_glitch = -1, fl_idx = 0, rsp_dly = 0;
  bit fl_exp = 0, rsp_pend = 0, stall = 0;
  // previous-cycle bus view for R5
  logic p_v = 0, p_r = 1, p_w = 0;
  logic [AW-1:0] p_a = '0;
  logic [7:0] p_d = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic void push(input logic [AW-1:0] a, input logic [7:0] d);
    qa.push_back(a); qd.push_back(d);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    m_done = 0; m_err = 0;
    if (!rst_n) begin
      ph = 0; qa.delete(); qd.delete();
    end else begin
      if (bus_valid && !bus_write && bus_ready) begin rsp_pend = 1; rsp_dly = 2; n_rd++; end
      if (bus_valid && bus_write && bus_ready) n_wr++;
      if (done) n_done++;
      if (timeout_err) n_err++;
      case (ph)
        0: if (req_valid && req_op != 2'd3) begin
          m_op = req_op; m_miss = 0; m_conf = 0;
          push(AW'(16'h5555), 8'hAA); push(AW'(16'h2AAA), 8'h55);
          if (req_op == 2'd0) begin
            push(AW'(16'h5555), 8'hA0); push(req_addr, req_data);
            m_exp = req_data[7]; m_pa = req_addr; m_lim = PP;
          end else begin
            push(AW'(16'h5555), 8'h80); push(AW'(16'h5555), 8'hAA);
            push(AW'(16'h2AAA), 8'h55);
            m_exp = 1;
            if (req_op == 2'd1) begin
              push({req_sector, 16'h0000}, 8'h30); m_pa = {req_sector, 16'h0000}; m_lim = SP;
            end else begin
              push(AW'(16'h5555), 8'h10); m_pa = '0; m_lim = CP;
            end
          end
          ph = 1;
        end
        1: if (bus_ready) begin
          void'(qa.pop_front()); void'(qd.pop_front());
          if (qa.size() == 0) ph = 2;
        end
        2: if (bus_ready) ph = 3;
        default: if (rd_valid) begin
          if (rd_data[7] == m_exp) begin
            if (m_conf) begin m_done = 1; ph = 0; end
            else begin m_conf = 1; ph = 2; end
          end else begin
            m_conf = 0; m_miss++;
            if (m_miss == m_lim) begin m_err = 1; ph = 0; end
            else ph = 2;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    string wtag;
    bit b7;
    bus_ready = stall ? (cyc % 3 != 1) : 1'b1;
    rd_valid = 0;
    if (rsp_pend) begin
      rsp_dly--;
      if (rsp_dly == 0) begin
        rsp_pend = 0; rd_valid = 1;
        b7 = (fl_idx < fl_busy) ? ~fl_exp : fl_exp;
        if (fl_idx == fl_glitch) b7 = ~b7;
        rd_data = {b7, 7'(fl_idx)};
        fl_idx++;
      end
    end
    if (rst_n) begin
      chk(busy == (ph != 0), "R9 busy", busy, ph != 0);
      chk(req_ready == (ph == 0), "R9 req_ready", req_ready, ph == 0);
      chk(done == m_done, "R7 done", done, m_done);
      chk(timeout_err == m_err, "R8 timeout_err", timeout_err, m_err);
      chk(bus_valid == (ph == 1 || ph == 2), "R6 bus_valid", bus_valid, ph == 1 || ph == 2);
      if (ph == 1) begin
        wtag = (m_op == 0) ? "R2 write" : (m_op == 1) ? "R3 write" : "R4 write";
        chk(bus_write == 1, wtag, bus_write, 1);
        chk(bus_addr == qa[0], wtag, bus_addr, qa[0]);
        chk(bus_wdata == qd[0], wtag, bus_wdata, qd[0]);
      end else if (ph == 2) begin
        chk(bus_write == 0, "R6 read", bus_write, 0);
        chk(bus_addr == m_pa, "R6 poll addr", bus_addr, m_pa);
      end
      if (p_v && !p_r)
        chk(bus_valid && bus_write == p_w && bus_addr == p_a && bus_wdata == p_d,
            "R5 hold", bus_addr, p_a);
    end
    p_v = bus_valid; p_r = bus_ready; p_w = bus_write; p_a = bus_addr; p_d = bus_wdata;
  end

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [SW-1:0] s, input int bn, input int gl, input bit st,
                        input int exp_wr, input int exp_rd, input bit exp_ok, input string tag);
    n_wr = 0; n_rd = 0; n_done = 0; n_err = 0;
    fl_busy = bn; fl_glitch = gl; fl_idx = 0; stall = st;
    fl_exp = (op == 2'd0) ? d[7] : 1'b1;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_sector = s; req_valid = 1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(n_wr == exp_wr, {tag, " write count"}, n_wr, exp_wr);
    chk(n_rd == exp_rd, {tag, " read count"}, n_rd, exp_rd);
    chk(n_done == int'(exp_ok), {tag, " done pulses"}, n_done, exp_ok);
    chk(n_err == int'(!exp_ok), "R8 err pulses", n_err, !exp_ok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && bus_valid == 0 && done == 0 && timeout_err == 0, "R1 reset outputs", busy, 0);
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // program, bit7=1, 3 busy reads then match + confirm
    run_op(2'd0, 19'h12345, 8'hC3, 3'd0, 3, -1, 0, 4, 5, 1, "R2 program");
    // program, bit7=0, with back-pressure (R5)
    run_op(2'd0, 19'h7FFFE, 8'h5A, 3'd0, 2, -1, 1, 4, 4, 1, "R2 program stalled");
    // sector erase sector 5
    run_op(2'd1, 19'h0, 8'h00, 3'd5, 4, -1, 1, 6, 6, 1, "R3 sector erase");
    // chip erase
    run_op(2'd2, 19'h0, 8'h00, 3'd0, 2, -1, 0, 6, 4, 1, "R4 chip erase");
    // confirm read glitched: miss, resume polling
    run_op(2'd0, 19'h00100, 8'h80, 3'd0, 2, 3, 0, 4, 6, 1, "R7 confirm retry");
    // timeouts
    run_op(2'd0, 19'h00200, 8'h11, 3'd0, 100, -1, 0, 4, PP, 0, "R8 program timeout");
    run_op(2'd1, 19'h0, 8'h00, 3'd2, 100, -1, 1, 6, SP, 0, "R8 sector timeout");
    // R9: request held while busy is not taken
    n_wr = 0; fl_busy = 5; fl_glitch = -1; fl_idx = 0; fl_exp = 1; stall = 0;
    @(negedge clk);
    req_op = 2'd0; req_addr = 19'h00400; req_data = 8'hFF; req_valid = 1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk); req_op = 2'd2; req_addr = 19'h55555;
    repeat (8) @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    chk(n_wr == 4, "R9 held request ignored", n_wr, 4);
    // R10: op code 3 does nothing
    n_wr = 0; n_rd = 0;
    @(negedge clk); req_op = 2'd3; req_valid = 1;
    repeat (5) begin
      @(negedge clk);
      chk(busy == 0 && bus_valid == 0, "R10 no-op idle", busy, 0);
    end
    req_valid = 0;
    chk(n_wr == 0 && n_rd == 0, "R10 no bus traffic", n_wr + n_rd, 0);
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule